// File: doc/BRIEF.md
# Push-Pull Current-Mode PWM Sequencer

This block is the clocked cycle logic of a current-mode push-pull or bridge controller. An oscillator tick opens each switching half-period. The block gives successive half-periods to gate request A and gate request B in turn. It holds the chosen request low for a programmable number of clocks of dead time, then raises it. The request stays high until one of three things happens: the PWM comparator trips after its blanking window, the current-limit comparator trips, or the next tick arrives.

The two comparator results come in as synchronous single-bit signals. The PWM comparator result is masked for a programmable number of clocks at the start of every on-pulse. This keeps the switching spike from ending the pulse early. The current-limit result is never masked. A current-limit trip drops both requests and emits a single-clock event for an external fault integrator. Driving enable low forces both requests low at once. The next half-period after re-enable always belongs to side A.

Top module: `pp_pwm_seq`

## Requirements
- R1: Consecutive ticks alternate the active side. The first half-period after reset, and the first after enable returns high, drives `drv_a`. Each request is high for at most one half-period per two ticks.
- R2: `drv_a` and `drv_b` are never high in the same clock.
- R3: With `dead_bypass` low and `dead_cnt` = D > 0, the active request rises on the clock edge D cycles after the edge that sampled the tick. Both requests stay low in between.
- R4: With `dead_bypass` high, or with `dead_cnt` zero, the active request rises on the edge that samples the tick. Without a trip it stays high for the whole half-period, so one side may fall and the other rise in the same clock.
- R5: `pwm_trip` has no effect during the first `blank_cnt` clocks of an on-pulse. If `pwm_trip` is held high from the start, the pulse is exactly `blank_cnt`+1 clocks wide (minimum on-time).
- R6: Once blanking is over, `pwm_trip` high at a clock edge ends the pulse at that edge. The request stays low until the next tick.
- R7: `ilim_trip` high at a clock edge ends an on-pulse at that edge, including during blanking. Both requests are then low. If both comparators trip in the same clock, the current limit is the one recorded.
- R8: `ilim_evt` is high for exactly one clock, in the same clock in which the request drops because of a current-limit trip. It never pulses otherwise.
- R9: A tick ends a pulse still running. If the dead time is at least as long as the half-period, that half-period produces no pulse.
- R10: During reset, and in the same clock that `enable` is low, both requests and `ilim_evt` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Run enable; low forces outputs low and re-arms side A |
| osc_tick | input | 1 | One-clock pulse opening each half-period |
| pwm_trip | input | 1 | Synchronous PWM comparator result |
| ilim_trip | input | 1 | Synchronous current-limit comparator result |
| dead_cnt | input | DT_W | Dead time in clocks |
| dead_bypass | input | 1 | High removes the dead time |
| blank_cnt | input | BL_W | Leading-edge blanking length in clocks |
| drv_a | output | 1 | Gate request, side A |
| drv_b | output | 1 | Gate request, side B |
| ilim_evt | output | 1 | One-clock current-limit event |

## Verification
The case of most interest is a current-limit trip and a PWM trip reaching the sequencer in the same clock. The bench provokes this twice. The first time, both trips fall inside the blanking window: the pulse must be one clock wide and the event must pulse. The second time, both rise on the same edge after blanking: the pulse must end there, with the event present. A second coincidence happens with the dead time bypassed. One side falls on the tick that raises the other, and the scoreboard checks the start offset and width of each pulse, while a separate check confirms the two requests never overlap.

// File: rtl/pp_pwm_pkg.sv
package pp_pwm_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_DEAD = 2'd1,
    PH_ON   = 2'd2,
    PH_OFF  = 2'd3
  } phase_t;

  typedef enum logic {
    SIDE_A = 1'b0,
    SIDE_B = 1'b1
  } side_t;
endpackage

// File: rtl/pp_dwell_ctr.sv
module pp_dwell_ctr #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         busy,
  output logic         last
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt_q <= '0;
    else if (clr)         cnt_q <= '0;
    else if (load)        cnt_q <= load_val;
    else if (cnt_q != '0) cnt_q <= cnt_q - ONE;
  end

  assign busy = (cnt_q != '0);
  assign last = (cnt_q == ONE);
endmodule

// File: rtl/pp_side_steer.sv
module pp_side_steer
  import pp_pwm_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic rearm,
  input  logic advance,
  input  logic on,
  output logic drv_a,
  output logic drv_b
);
  side_t cur_q, nxt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q <= SIDE_A;
      nxt_q <= SIDE_A;
    end else if (rearm) begin
      nxt_q <= SIDE_A;
    end else if (advance) begin
      cur_q <= nxt_q;
      nxt_q <= (nxt_q == SIDE_A) ? SIDE_B : SIDE_A;
    end
  end

  for (genvar g = 0; g < 2; g++) begin : g_out
    logic req;
    assign req = on && (cur_q == side_t'(g));
    if (g == 0) begin : g_a
      assign drv_a = req;
    end else begin : g_b
      assign drv_b = req;
    end
  end
endmodule

// File: rtl/pp_pwm_seq.sv
module pp_pwm_seq
  import pp_pwm_pkg::*;
#(
  parameter int DT_W = 6,
  parameter int BL_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            enable,
  input  logic            osc_tick,
  input  logic            pwm_trip,
  input  logic            ilim_trip,
  input  logic [DT_W-1:0] dead_cnt,
  input  logic            dead_bypass,
  input  logic [BL_W-1:0] blank_cnt,
  output logic            drv_a,
  output logic            drv_b,
  output logic            ilim_evt
);
  phase_t ph_q, ph_n;
  logic   dead_load, blank_load, advance, evt_n, evt_q;
  logic   dead_busy, dead_last, blank_busy;
  logic   no_dead;

  assign no_dead = dead_bypass || (dead_cnt == '0);

  pp_dwell_ctr #(.W(DT_W)) u_dead (
    .clk(clk), .rst_n(rst_n), .clr(!enable), .load(dead_load),
    .load_val(dead_cnt), .busy(dead_busy), .last(dead_last)
  );

  pp_dwell_ctr #(.W(BL_W)) u_blank (
    .clk(clk), .rst_n(rst_n), .clr(!enable), .load(blank_load),
    .load_val(blank_cnt), .busy(blank_busy), .last()
  );

  always_comb begin
    ph_n       = ph_q;
    dead_load  = 1'b0;
    blank_load = 1'b0;
    advance    = 1'b0;
    evt_n      = 1'b0;
    if (!enable) begin
      ph_n = PH_IDLE;
    end else begin
      if (ph_q == PH_ON && ilim_trip) evt_n = 1'b1;
      if (osc_tick) begin
        advance = 1'b1;
        if (no_dead) begin
          ph_n       = PH_ON;
          blank_load = 1'b1;
        end else begin
          ph_n      = PH_DEAD;
          dead_load = 1'b1;
        end
      end else begin
        unique case (ph_q)
          PH_DEAD: if (dead_last || !dead_busy) begin
            ph_n       = PH_ON;
            blank_load = 1'b1;
          end
          PH_ON: if (ilim_trip || (pwm_trip && !blank_busy)) ph_n = PH_OFF;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_IDLE;
      evt_q <= 1'b0;
    end else begin
      ph_q  <= ph_n;
      evt_q <= evt_n;
    end
  end

  assign ilim_evt = evt_q && enable;

  pp_side_steer u_steer (
    .clk(clk), .rst_n(rst_n), .rearm(!enable), .advance(advance),
    .on((ph_q == PH_ON) && enable), .drv_a(drv_a), .drv_b(drv_b)
  );
endmodule

// File: rtl/pp_pwm_seq_chk.sv
module pp_pwm_seq_chk #(
  parameter int DT_W = 6,
  parameter int BL_W = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            enable,
  input logic            osc_tick,
  input logic            pwm_trip,
  input logic            ilim_trip,
  input logic [DT_W-1:0] dead_cnt,
  input logic            dead_bypass,
  input logic [BL_W-1:0] blank_cnt,
  input logic            drv_a,
  input logic            drv_b,
  input logic            ilim_evt
);
  // R2
  a_r2_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(drv_a && drv_b));

  // R7
  a_r7_ilim_drops_a: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_a && ilim_trip && enable && !osc_tick) |=> (!drv_a && !drv_b));

  a_r7_ilim_drops_b: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_b && ilim_trip && enable && !osc_tick) |=> (!drv_a && !drv_b));

  // R8
  a_r8_evt_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    ilim_evt |-> ($past(ilim_trip) && $past(drv_a || drv_b)));

  // R3
  a_r3_dead_gap: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(drv_a) && !dead_bypass && dead_cnt != '0) |-> !drv_b);

  // R10
  a_r10_disable_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!enable) && !enable |-> (!drv_a && !drv_b && !ilim_evt));
endmodule

bind pp_pwm_seq pp_pwm_seq_chk #(.DT_W(DT_W), .BL_W(BL_W)) chk_i (.*);

// File: tb/pp_pwm_seq_tb_top.sv
`timescale 1ns/1ps
module pp_pwm_seq_tb_top;
  localparam int DTW = 6;
  localparam int BLW = 4;

  logic clk = 1'b0, rst_n = 1'b0, enable = 1'b0;
  logic osc_tick = 1'b0, pwm_trip = 1'b0, ilim_trip = 1'b0, dead_bypass = 1'b0;
  logic [DTW-1:0] dead_cnt = '0;
  logic [BLW-1:0] blank_cnt = '0;
  logic drv_a, drv_b, ilim_evt;

  always #2.5 clk = ~clk;

  pp_pwm_seq #(.DT_W(DTW), .BL_W(BLW)) dut_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .osc_tick(osc_tick),
    .pwm_trip(pwm_trip), .ilim_trip(ilim_trip), .dead_cnt(dead_cnt),
    .dead_bypass(dead_bypass), .blank_cnt(blank_cnt),
    .drv_a(drv_a), .drv_b(drv_b), .ilim_evt(ilim_evt)
  );

  typedef struct {bit side; int start; int width; bit evt;} pulse_t;
  pulse_t expq[$];
  int  n_chk = 0, n_fail = 0;
  bit  exp_side = 1'b0;
  bit  mon_en = 1'b0;
  bit  done = 1'b0;

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int imax(int x, int y); return (x > y) ? x : y; endfunction
  function automatic int imin(int x, int y); return (x < y) ? x : y; endfunction

  // Driver: computes the expected pulse of one half-period, then drives it.
  task automatic run_cycle(int half, int pk, int ik);
    int s, pe, ie, fin;
    pulse_t it;
    s   = (dead_bypass || dead_cnt == 0) ? 0 : int'(dead_cnt);
    pe  = (pk > 0) ? imax(pk, s + int'(blank_cnt) + 1) : 1 << 20;
    ie  = (ik > 0) ? imax(ik, s + 1) : 1 << 20;
    fin = imin(imin(pe, ie), half);
    if (s < half) begin
      it.side = exp_side; it.start = s; it.width = fin - s;
      it.evt  = (ie <= pe) && (ie <= half);
      expq.push_back(it);
    end
    exp_side = ~exp_side;
    for (int k = 0; k < half; k++) begin
      @(negedge clk);
      osc_tick  = (k == 0);
      pwm_trip  = (pk > 0) && (k >= pk);
      ilim_trip = (ik > 0) && (k >= ik);
    end
  endtask

  task automatic quiet(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      osc_tick = 1'b0; pwm_trip = 1'b0; ilim_trip = 1'b0;
    end
  endtask

  // Monitor: measures each pulse and compares it with the scoreboard.
  int since = 0;
  bit pa = 0, pb = 0;
  int sa = 0, sb = 0, wa = 0, wb = 0;

  task automatic close_pulse(bit side, int st, int w);
    pulse_t e;
    if (!mon_en) return;
    if (expq.size() == 0) begin
      check(1'b0, "R1", "unexpected pulse on side", int'(side), -1);
      return;
    end
    e = expq.pop_front();
    check(side == e.side, "R1", "side", int'(side), int'(e.side));
    check(st == e.start, "R3/R4", "start offset", st, e.start);
    check(w == e.width, "R5/R6/R7/R9", "width", w, e.width);
    check(ilim_evt == e.evt, "R8", "event at fall", int'(ilim_evt), int'(e.evt));
  endtask

  always @(posedge clk) begin
    #1;
    if (rst_n) begin
      bit fa, fb;
      since = osc_tick ? 0 : since + 1;
      if (drv_a === 1'b1 && drv_b === 1'b1)
        check(1'b0, "R2", "both requests high", 1, 0);
      fa = pa && !drv_a;
      fb = pb && !drv_b;
      if (ilim_evt && !fa && !fb && mon_en)
        check(1'b0, "R8", "event without a fall", 1, 0);
      if (fa) close_pulse(1'b0, sa, wa);
      if (fb) close_pulse(1'b1, sb, wb);
      if (drv_a && !pa) begin sa = since; wa = 0; end
      if (drv_b && !pb) begin sb = since; wb = 0; end
      if (drv_a) wa++;
      if (drv_b) wb++;
      pa = drv_a; pb = drv_b;
    end
  end

  task automatic finish_up();
    if (done) return;
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    check(1'b0, "R1", "watchdog expired", 1, 0);
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(drv_a == 1'b0 && drv_b == 1'b0, "R10", "requests in reset", int'({drv_a, drv_b}), 0);
    check(ilim_evt == 1'b0, "R10", "event in reset", int'(ilim_evt), 0);
    rst_n = 1'b1; enable = 1'b1;
    dead_cnt = 6'd2; blank_cnt = 4'd3; dead_bypass = 1'b0;
    mon_en = 1'b1;
    quiet(2);

    run_cycle(12, 8, 0);   // R3 R6: A, start 2, width 6
    run_cycle(12, 3, 0);   // R5: B, pwm inside blanking, width 4
    run_cycle(12, 3, 3);   // R7 R8: A, both trips in blanking, width 1, event
    run_cycle(12, 0, 0);   // R9: B, ended by next tick, width 10
    run_cycle(12, 0, 9);   // R7: A, width 7, event
    dead_bypass = 1'b1;
    run_cycle(12, 0, 0);   // R4: B full half-period
    run_cycle(12, 0, 0);   // R4: A rises as B falls
    run_cycle(12, 5, 0);   // R6: B width 5
    dead_bypass = 1'b0; dead_cnt = 6'd0;
    run_cycle(8, 2, 0);    // R4 R5: A start 0, width 4
    dead_cnt = 6'd2;
    run_cycle(12, 7, 7);   // R7: B tie after blanking, width 5, event
    dead_cnt = 6'd5;
    run_cycle(4, 0, 0);    // R9: dead >= half, A slot empty
    run_cycle(12, 8, 0);   // R9 R1: B start 5, width 4
    quiet(3);
    check(expq.size() == 0, "R1", "pending pulses before disable", expq.size(), 0);

    // R10 and R1: disable mid-pulse, then restart on side A
    mon_en = 1'b0;
    dead_cnt = 6'd0; blank_cnt = 4'd0;
    @(negedge clk); osc_tick = 1'b1;
    @(negedge clk); osc_tick = 1'b0; ilim_trip = 1'b0;
    @(negedge clk);
    check((drv_a || drv_b) == 1'b1, "R10", "pulse running before disable", int'(drv_a || drv_b), 1);
    enable = 1'b0; ilim_trip = 1'b1;
    #1;
    check(drv_a == 1'b0 && drv_b == 1'b0, "R10", "requests same clock as disable", int'({drv_a, drv_b}), 0);
    repeat (3) @(negedge clk);
    check(ilim_evt == 1'b0 && drv_a == 1'b0 && drv_b == 1'b0, "R10", "quiet while disabled",
          int'({drv_a, drv_b, ilim_evt}), 0);
    ilim_trip = 1'b0;
    enable = 1'b1;
    dead_cnt = 6'd2; blank_cnt = 4'd3;
    exp_side = 1'b0;
    @(negedge clk);
    mon_en = 1'b1;
    run_cycle(12, 8, 0);   // R1: first after re-enable is A, start 2, width 6
    quiet(4);
    check(expq.size() == 0, "R1", "pending pulses at end", expq.size(), 0);
    finish_up();
  end
endmodule